// File: doc/BRIEF.md
# System Exception Control Register Slice

This block is the register-facing part of an interrupt controller's system control space. Software reaches it over a simple 32-bit register bus with a write strobe, a 2-bit word select, write data and combinational read data. Through it, software can pend the non-maskable exception. It can also pend or un-pend the pendable service exception and the tick exception. It can hold the vector table base, request a system reset behind a 16-bit key, and pend any external interrupt by number. Deciding priority between exceptions is done elsewhere.

The prioritiser feeds in its view of the world: the active vector, the highest pending vector, whether any external interrupt is pending, whether an external interrupt other than the current one is active, and the pending state of the three system exceptions. A read of the control/state word packs these into fixed bit positions. Writes become one-cycle strobes toward the prioritiser, registered so that each appears in the clock cycle after the write.

The reset request is driven by a two-state machine. `RQ_IDLE` moves to `RQ_FIRE` on a keyed write with the reset bit set. `RQ_FIRE` always returns to `RQ_IDLE` on the next clock, so the request is exactly one cycle wide.

Top module: `sys_exc_ctl`

## Requirements
- R1: After reset, every strobe output, `rst_req_o` and `trig_stb_o` are low, and `vec_base_o` is zero.
- R2: A write to word 0 with bit 31 set makes `nmi_set_o` high for exactly the one cycle after the write.
- R3: On a word 0 write, bit 28 pulses `sv_set_o` and bit 27 pulses `sv_clr_o`. When both bits are 1, only `sv_set_o` pulses.
- R4: On a word 0 write, bit 26 pulses `tick_set_o` and bit 25 pulses `tick_clr_o`. When both bits are 1, only `tick_set_o` pulses.
- R5: A read of word 0 returns the following fields; all other bits read as 0:
  - bits [8:0]: the active vector, or 0 when none is active.
  - bit 11: the other-active flag.
  - bits [20:12]: the highest pending vector, or 0 when nothing is pending.
  - bit 22: the any-external-pending flag.
  - bit 26: tick pending.
  - bit 28: service pending.
  - bit 31: non-maskable pending.
- R6: A write to word 2 whose bits [31:16] equal 0x05FA and whose bit 2 is 1 makes `rst_req_o` high for exactly the one cycle after the write. With any other key, the write has no effect.
- R7: A read of word 2 returns 0xFA050000.
- R8: A write to word 1 stores the written value with bits [6:0] forced to 0. The stored value appears on `vec_base_o` and is returned by reads of word 1.
- R9: A write to word 3 whose bits [8:0] hold a number below `NUM_IRQ` makes `trig_stb_o` high for the one cycle after the write. If the number is `NUM_IRQ` or higher, the write is ignored.
- R10: While `trig_stb_o` is high, `trig_vec_o` holds the written number plus 16, since external vectors start at 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word select: 0 control/state, 1 vector base, 2 reset control, 3 software trigger |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ic_act_valid | input | 1 | An exception is active |
| ic_act_vec | input | 9 | Active vector number |
| ic_pend_valid | input | 1 | Something is pending |
| ic_pend_vec | input | 9 | Highest pending vector number |
| ic_other_active | input | 1 | An external interrupt other than the current one is active |
| ic_ext_pend | input | 1 | Any external interrupt pending |
| ic_nmi_pend | input | 1 | Non-maskable exception pending |
| ic_sv_pend | input | 1 | Service exception pending |
| ic_tick_pend | input | 1 | Tick exception pending |
| nmi_set_o | output | 1 | Pend non-maskable exception |
| sv_set_o | output | 1 | Pend service exception |
| sv_clr_o | output | 1 | Un-pend service exception |
| tick_set_o | output | 1 | Pend tick exception |
| tick_clr_o | output | 1 | Un-pend tick exception |
| rst_req_o | output | 1 | One-cycle system reset request |
| vec_base_o | output | 32 | Vector table base |
| trig_stb_o | output | 1 | Software trigger strobe |
| trig_vec_o | output | 10 | Vector number of the triggered interrupt |

## Verification
The bench builds the block with `NUM_IRQ` = 40 rather than the default of 64. This places the acceptance edge of the software trigger at numbers 39 and 40, and both sides of that edge can be driven directly. The 9-bit number field can then exceed the limit by a wide margin: 511 is written to show it is discarded rather than wrapped. With the same setting, the highest accepted number shows that `trig_vec_o` reaches 55.

// File: rtl/sys_exc_pkg.sv
package sys_exc_pkg;
    localparam int unsigned REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        SEL_CTLSTAT = 2'd0,
        SEL_VBASE   = 2'd1,
        SEL_RSTCTL  = 2'd2,
        SEL_SWTRIG  = 2'd3
    } reg_sel_e;

    localparam logic [15:0] RST_KEY       = 16'h05FA;
    localparam logic [31:0] RSTCTL_RDVAL  = 32'hFA05_0000;
    localparam int unsigned EXT_VEC_BASE  = 16;

    typedef enum logic {
        RQ_IDLE,
        RQ_FIRE
    } rq_state_e;
endpackage

// File: rtl/sys_exc_pend.sv
module sys_exc_pend (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic [6:0] ctl_bits,   // written bits [31:25]
    output logic       nmi_set_o,
    output logic       sv_set_o,
    output logic       sv_clr_o,
    output logic       tick_set_o,
    output logic       tick_clr_o
);
    logic nmi_d, svs_d, svc_d, tks_d, tkc_d;

    always_comb begin
        nmi_d = hit && ctl_bits[6];
        svs_d = hit && ctl_bits[3];
        svc_d = hit && ctl_bits[2] && !ctl_bits[3];
        tks_d = hit && ctl_bits[1];
        tkc_d = hit && ctl_bits[0] && !ctl_bits[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_set_o  <= 1'b0;
            sv_set_o   <= 1'b0;
            sv_clr_o   <= 1'b0;
            tick_set_o <= 1'b0;
            tick_clr_o <= 1'b0;
        end else begin
            nmi_set_o  <= nmi_d;
            sv_set_o   <= svs_d;
            sv_clr_o   <= svc_d;
            tick_set_o <= tks_d;
            tick_clr_o <= tkc_d;
        end
    end
endmodule

// File: rtl/sys_exc_rstreq.sv
module sys_exc_rstreq
    import sys_exc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hit,
    input  logic [15:0] key,
    input  logic        req_bit,
    output logic        rst_req_o
);
    rq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_IDLE: if (hit && key == RST_KEY && req_bit) state_d = RQ_FIRE;
            RQ_FIRE: state_d = RQ_IDLE;
            default: state_d = RQ_IDLE;
        endcase
    end

    always_comb begin
        rst_req_o = (state_q == RQ_FIRE);
    end
endmodule

// File: rtl/sys_exc_swtrig.sv
module sys_exc_swtrig #(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned NUM_W   = 9,
    parameter int unsigned TV_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [NUM_W-1:0] num,
    output logic             trig_stb_o,
    output logic [TV_W-1:0]  trig_vec_o
);
    localparam int unsigned VBASE = sys_exc_pkg::EXT_VEC_BASE;

    logic in_range;
    always_comb in_range = (32'(num) < NUM_IRQ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_stb_o <= 1'b0;
            trig_vec_o <= '0;
        end else begin
            trig_stb_o <= hit && in_range;
            if (hit && in_range) trig_vec_o <= TV_W'(num) + TV_W'(VBASE);
        end
    end
endmodule

// File: rtl/sys_exc_ctl.sv
module sys_exc_ctl
    import sys_exc_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned VEC_W   = 9,
    parameter int unsigned TV_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ic_act_valid,
    input  logic [VEC_W-1:0]  ic_act_vec,
    input  logic              ic_pend_valid,
    input  logic [VEC_W-1:0]  ic_pend_vec,
    input  logic              ic_other_active,
    input  logic              ic_ext_pend,
    input  logic              ic_nmi_pend,
    input  logic              ic_sv_pend,
    input  logic              ic_tick_pend,
    output logic              nmi_set_o,
    output logic              sv_set_o,
    output logic              sv_clr_o,
    output logic              tick_set_o,
    output logic              tick_clr_o,
    output logic              rst_req_o,
    output logic [31:0]       vec_base_o,
    output logic              trig_stb_o,
    output logic [TV_W-1:0]   trig_vec_o
);
    localparam int unsigned PEND_LSB = 12;
    localparam int unsigned NUM_W    = 9;
    localparam int unsigned VB_LSB   = 7;

    reg_sel_e sel;
    logic hit_cs, hit_vb, hit_rc, hit_st;

    always_comb begin
        sel    = reg_sel_e'(bus_addr);
        hit_cs = bus_wr && sel == SEL_CTLSTAT;
        hit_vb = bus_wr && sel == SEL_VBASE;
        hit_rc = bus_wr && sel == SEL_RSTCTL;
        hit_st = bus_wr && sel == SEL_SWTRIG;
    end

    sys_exc_pend u_pend (
        .clk(clk), .rst_n(rst_n), .hit(hit_cs), .ctl_bits(bus_wdata[31:25]),
        .nmi_set_o(nmi_set_o), .sv_set_o(sv_set_o), .sv_clr_o(sv_clr_o),
        .tick_set_o(tick_set_o), .tick_clr_o(tick_clr_o)
    );

    sys_exc_rstreq u_rst (
        .clk(clk), .rst_n(rst_n), .hit(hit_rc), .key(bus_wdata[31:16]),
        .req_bit(bus_wdata[2]), .rst_req_o(rst_req_o)
    );

    sys_exc_swtrig #(.NUM_IRQ(NUM_IRQ), .NUM_W(NUM_W), .TV_W(TV_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .hit(hit_st), .num(bus_wdata[NUM_W-1:0]),
        .trig_stb_o(trig_stb_o), .trig_vec_o(trig_vec_o)
    );

    logic [31:VB_LSB] vb_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      vb_q <= '0;
        else if (hit_vb) vb_q <= bus_wdata[31:VB_LSB];
    end
    assign vec_base_o = {vb_q, {VB_LSB{1'b0}}};

    logic [31:0] cs_word;
    always_comb begin
        cs_word = '0;
        if (ic_act_valid)  cs_word[VEC_W-1:0] = ic_act_vec;
        if (ic_pend_valid) cs_word[PEND_LSB +: VEC_W] = ic_pend_vec;
        cs_word[11] = ic_other_active;
        cs_word[22] = ic_ext_pend;
        cs_word[26] = ic_tick_pend;
        cs_word[28] = ic_sv_pend;
        cs_word[31] = ic_nmi_pend;
    end

    always_comb begin
        unique case (sel)
            SEL_CTLSTAT: bus_rdata = cs_word;
            SEL_VBASE:   bus_rdata = vec_base_o;
            SEL_RSTCTL:  bus_rdata = RSTCTL_RDVAL;
            SEL_SWTRIG:  bus_rdata = '0;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sys_exc_ctl_chk.sv
module sys_exc_ctl_chk #(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned TV_W    = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic [1:0]      bus_addr,
    input logic [31:0]     bus_wdata,
    input logic [31:0]     bus_rdata,
    input logic            sv_set_o,
    input logic            sv_clr_o,
    input logic            tick_set_o,
    input logic            tick_clr_o,
    input logic            rst_req_o,
    input logic [31:0]     vec_base_o,
    input logic            trig_stb_o,
    input logic [TV_W-1:0] trig_vec_o
);
    assert_sv_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sv_clr_o |-> !sv_set_o);

    assert_tick_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_clr_o |-> !tick_set_o);

    assert_rst_keyed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(bus_wr && bus_addr == 2'd2 &&
                            bus_wdata[31:16] == 16'h05FA && bus_wdata[2]));

    assert_rst_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    assert_rstctl_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 2'd2 |-> bus_rdata == 32'hFA05_0000);

    assert_vbase_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_base_o[6:0] == 7'd0);

    assert_trig_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_stb_o |-> (32'(trig_vec_o) >= 32'd16 && 32'(trig_vec_o) < NUM_IRQ + 16));
endmodule

bind sys_exc_ctl sys_exc_ctl_chk #(.NUM_IRQ(NUM_IRQ), .TV_W(TV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sv_set_o(sv_set_o),
    .sv_clr_o(sv_clr_o), .tick_set_o(tick_set_o), .tick_clr_o(tick_clr_o),
    .rst_req_o(rst_req_o), .vec_base_o(vec_base_o), .trig_stb_o(trig_stb_o),
    .trig_vec_o(trig_vec_o)
);

// File: tb/sys_exc_ctl_test.sv
`timescale 1ns/1ps
module sys_exc_ctl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic ic_act_valid = 0, ic_pend_valid = 0, ic_other_active = 0, ic_ext_pend = 0;
    logic ic_nmi_pend = 0, ic_sv_pend = 0, ic_tick_pend = 0;
    logic [8:0] ic_act_vec = '0, ic_pend_vec = '0;
    logic nmi_set_o, sv_set_o, sv_clr_o, tick_set_o, tick_clr_o, rst_req_o, trig_stb_o;
    logic [31:0] vec_base_o;
    logic [9:0] trig_vec_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    sys_exc_ctl #(.NUM_IRQ(40)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ic_act_valid(ic_act_valid), .ic_act_vec(ic_act_vec),
        .ic_pend_valid(ic_pend_valid), .ic_pend_vec(ic_pend_vec),
        .ic_other_active(ic_other_active), .ic_ext_pend(ic_ext_pend),
        .ic_nmi_pend(ic_nmi_pend), .ic_sv_pend(ic_sv_pend), .ic_tick_pend(ic_tick_pend),
        .nmi_set_o(nmi_set_o), .sv_set_o(sv_set_o), .sv_clr_o(sv_clr_o),
        .tick_set_o(tick_set_o), .tick_clr_o(tick_clr_o), .rst_req_o(rst_req_o),
        .vec_base_o(vec_base_o), .trig_stb_o(trig_stb_o), .trig_vec_o(trig_vec_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] strobes();
        return {25'd0, rst_req_o, trig_stb_o, nmi_set_o, sv_set_o, sv_clr_o, tick_set_o, tick_clr_o};
    endfunction

    // drive a write for one cycle; on return the registered outputs for it are visible
    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        check("R1 strobes", strobes(), 32'd0);
        check("R1 vbase", vec_base_o, 32'd0);
    endtask

    task automatic t_nmi();
        bus_write(2'd0, 32'h8000_0000);
        check("R2 nmi pulse", strobes(), 32'h10);
        @(negedge clk);
        check("R2 nmi one cycle", strobes(), 32'd0);
    endtask

    task automatic t_service();
        bus_write(2'd0, 32'h1000_0000);
        check("R3 set", strobes(), 32'h08);
        bus_write(2'd0, 32'h0800_0000);
        check("R3 clear", strobes(), 32'h04);
        bus_write(2'd0, 32'h1800_0000);
        check("R3 set wins", strobes(), 32'h08);
    endtask

    task automatic t_tick();
        bus_write(2'd0, 32'h0400_0000);
        check("R4 set", strobes(), 32'h02);
        bus_write(2'd0, 32'h0200_0000);
        check("R4 clear", strobes(), 32'h01);
        bus_write(2'd0, 32'h0600_0000);
        check("R4 set wins", strobes(), 32'h02);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        ic_act_valid = 0; ic_pend_valid = 0;
        bus_read(2'd0, d);
        check("R5 idle", d, 32'd0);
        ic_act_valid = 1; ic_act_vec = 9'd21; ic_pend_valid = 1; ic_pend_vec = 9'd300;
        ic_other_active = 1; ic_ext_pend = 1; ic_tick_pend = 1; ic_sv_pend = 1; ic_nmi_pend = 1;
        bus_read(2'd0, d);
        check("R5 full", d, 32'h9400_0000 | 32'h0040_0000 | (32'd300 << 12) | 32'h800 | 32'd21);
        ic_other_active = 0; ic_ext_pend = 0; ic_tick_pend = 0; ic_nmi_pend = 0;
        ic_pend_valid = 0;
        bus_read(2'd0, d);
        check("R5 partial", d, 32'h1000_0000 | 32'd21);
        ic_act_valid = 0; ic_sv_pend = 0;
    endtask

    task automatic t_reset_req();
        logic [31:0] d;
        bus_write(2'd2, 32'h05FB_0004);
        check("R6 bad key", strobes(), 32'd0);
        bus_write(2'd2, 32'h05FA_0000);
        check("R6 key no bit", strobes(), 32'd0);
        bus_write(2'd2, 32'h05FA_0004);
        check("R6 pulse", strobes(), 32'h40);
        @(negedge clk);
        check("R6 one cycle", strobes(), 32'd0);
        bus_read(2'd2, d);
        check("R7 readback", d, 32'hFA05_0000);
    endtask

    task automatic t_vbase();
        logic [31:0] d;
        bus_write(2'd1, 32'h2000_01FF);
        check("R8 port", vec_base_o, 32'h2000_0180);
        bus_read(2'd1, d);
        check("R8 read", d, 32'h2000_0180);
    endtask

    task automatic t_trigger();
        bus_write(2'd3, 32'd0);
        check("R9 num 0", strobes(), 32'h20);
        check("R10 vec 16", {22'd0, trig_vec_o}, 32'd16);
        bus_write(2'd3, 32'd39);
        check("R9 num 39", strobes(), 32'h20);
        check("R10 vec 55", {22'd0, trig_vec_o}, 32'd55);
        bus_write(2'd3, 32'd40);
        check("R9 num 40 ignored", strobes(), 32'd0);
        bus_write(2'd3, 32'h0000_01FF);
        check("R9 num 511 ignored", strobes(), 32'd0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nmi();
        t_service();
        t_tick();
        t_readback();
        t_reset_req();
        t_vbase();
        t_trigger();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule